// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides, for every fetch, load or store that a 32-bit core issues, whether the access may go ahead. It holds a table of programmable address regions. Each region carries its own read, write and execute rights, a matching mode and a lock bit. When the core runs below machine privilege, an access must fall inside a region that grants the requested right. In machine privilege, accesses are allowed unless a locked region says otherwise.

Software programs the table through a small register port. Config words pack one byte per entry, and each entry also has its own address register. The check side takes an address, an access type and the current privilege, and it returns a registered allow/deny bit one cycle later. Trap generation, instruction decoding and address translation belong to the surrounding core.

Top module: `pmp_checker`

## Requirements
- R1: After reset every config byte and address register reads zero. A user access is then denied and a machine access is allowed.
- R2: Register index w (0..3) is config word w, and entry i sits in byte i%4 of word i/4. Index 16+i is the address register of entry i. Reads return the stored value, and config bits 6:5 always read zero. Any other index reads zero and ignores writes.
- R3: A config byte uses bit0 for R, bit1 for W, bit2 for X, bits4:3 for mode (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two) and bit7 for lock. In top-of-range mode, entry i matches when addr[i-1] <= A[33:2] < addr[i]. Entry 0 uses zero as its lower bound.
- R4: In four-byte mode an entry matches exactly when A[33:2] equals its address register.
- R5: In power-of-two mode, a run of k trailing ones in the address register selects a naturally aligned region of 2^(k+3) bytes. The region's base comes from the remaining upper bits.
- R6: Access type 0 is a read and needs R, type 1 is a write and needs W, and type 2 is an execute and needs X. Type 3 is never granted by a region.
- R7: When several entries match, only the lowest-numbered one decides.
- R8: If no entry matches, a user (0) or supervisor (1) access is denied and a machine (3) access is allowed.
- R9: In machine privilege, a matching unlocked entry allows any access. A matching locked entry enforces its rights.
- R10: Writes to a locked entry's config byte and to its address register are ignored. The lock stays set until reset.
- R11: When entry i+1 is locked and in top-of-range mode, writes to the address register of entry i are ignored.
- R12: res_valid and res_allow appear exactly one cycle after chk_valid, for each request.
- R13: An entry in the off mode never matches, whatever its address register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Register write strobe |
| csr_idx | input | 6 | Register index |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational) |
| chk_valid | input | 1 | Access request strobe |
| chk_addr | input | 34 | Physical byte address |
| chk_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| chk_priv | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| res_valid | output | 1 | Result strobe, one cycle after request |
| res_allow | output | 1 | 1 when the access is permitted |

## Verification
The bench builds the checker with its default of sixteen entries. This brings the fourth config word and the highest address index (31) within reach, so entry 15 is programmed and matched. With sixteen entries, a top-of-range pair, a four-byte region, two nested power-of-two regions and an off entry can all be live at once. Lowest-index priority and the lock coupling between a top-of-range entry and its lower neighbour are therefore checked in one table.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

    localparam int CSR_IDX_W  = 6;
    localparam int ADDR_BASE  = 16;
    localparam int WORD_W     = 32;
    localparam int PHYS_W     = 34;
    localparam int PER_WORD   = 4;

    localparam logic [1:0] PRIV_M = 2'd3;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_TOR   = 2'd1,
        MODE_NA4   = 2'd2,
        MODE_NAPOT = 2'd3
    } pmp_mode_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_NONE  = 2'd3
    } pmp_acc_e;

    typedef struct packed {
        logic      lock;
        logic [1:0] rsvd;
        pmp_mode_e mode;
        logic      x;
        logic      w;
        logic      r;
    } pmp_cfg_t;

    // Clear reserved bits of an incoming config byte.
    function automatic pmp_cfg_t cfg_from_byte(input logic [7:0] b);
        pmp_cfg_t c;
        c      = pmp_cfg_t'(b);
        c.rsvd = 2'b00;
        return c;
    endfunction

    // Bits of a power-of-two address register that must compare equal.
    function automatic logic [WORD_W-1:0] napot_care(input logic [WORD_W-1:0] a);
        return ~(a ^ (a + 1'b1));
    endfunction

    // Right granted for one access type from an {x,w,r} triple.
    function automatic logic right_ok(input logic [2:0] xwr, input pmp_acc_e acc);
        case (acc)
            ACC_READ:  return xwr[0];
            ACC_WRITE: return xwr[1];
            ACC_EXEC:  return xwr[2];
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pmp_csr_file.sv
module pmp_csr_file
    import pmp_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              csr_we,
    input  logic [CSR_IDX_W-1:0]              csr_idx,
    input  logic [WORD_W-1:0]                 csr_wdata,
    output logic [WORD_W-1:0]                 csr_rdata,
    output pmp_cfg_t [NUM_ENTRIES-1:0]        cfg_o,
    output logic [NUM_ENTRIES-1:0][WORD_W-1:0] addr_o,
    output logic                              any_lock_o
);

    localparam int CFG_WORDS = (NUM_ENTRIES + PER_WORD - 1) / PER_WORD;

    pmp_cfg_t [NUM_ENTRIES-1:0]         cfg_q;
    logic [NUM_ENTRIES-1:0][WORD_W-1:0] addr_q;
    logic [NUM_ENTRIES-1:0]             addr_frozen;

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
        localparam int WIDX = i / PER_WORD;
        localparam int BOFS = 8 * (i % PER_WORD);

        logic cfg_hit;
        logic addr_hit;
        assign cfg_hit  = csr_we && (csr_idx == CSR_IDX_W'(WIDX));
        assign addr_hit = csr_we && (csr_idx == CSR_IDX_W'(ADDR_BASE + i));

        if (i < NUM_ENTRIES - 1) begin : g_nb
            assign addr_frozen[i] = cfg_q[i].lock ||
                                    (cfg_q[i+1].lock && (cfg_q[i+1].mode == MODE_TOR));
        end else begin : g_last
            assign addr_frozen[i] = cfg_q[i].lock;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[i]  <= '0;
                addr_q[i] <= '0;
            end else begin
                if (cfg_hit && !cfg_q[i].lock)
                    cfg_q[i] <= cfg_from_byte(csr_wdata[BOFS +: 8]);
                if (addr_hit && !addr_frozen[i])
                    addr_q[i] <= csr_wdata;
            end
        end

        // R10: a locked entry keeps its config and address
        p_cfg_hold_r10: assert property (@(posedge clk) disable iff (rst)
            cfg_q[i].lock |=> $stable(cfg_q[i]));
        p_addr_hold_r10: assert property (@(posedge clk) disable iff (rst)
            cfg_q[i].lock |=> $stable(addr_q[i]));

        if (i < NUM_ENTRIES - 1) begin : g_tor_chk
            // R11: a locked top-of-range neighbour freezes this address
            p_tor_prev_hold_r11: assert property (@(posedge clk) disable iff (rst)
                (cfg_q[i+1].lock && cfg_q[i+1].mode == MODE_TOR) |=> $stable(addr_q[i]));
        end
    end

    always_comb begin
        csr_rdata = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (csr_idx == CSR_IDX_W'(i / PER_WORD))
                csr_rdata[8*(i%PER_WORD) +: 8] = cfg_q[i];
            if (csr_idx == CSR_IDX_W'(ADDR_BASE + i))
                csr_rdata = addr_q[i];
        end
    end

    always_comb begin
        any_lock_o = 1'b0;
        for (int i = 0; i < NUM_ENTRIES; i++)
            any_lock_o = any_lock_o | cfg_q[i].lock;
    end

    assign cfg_o  = cfg_q;
    assign addr_o = addr_q;

    // R2: reserved config bits never read back as one
    p_rsvd_read_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (csr_idx < CSR_IDX_W'(CFG_WORDS)) |-> ((csr_rdata & 32'h6060_6060) == '0));

endmodule

// File: rtl/pmp_region_match.sv
module pmp_region_match
    import pmp_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [WORD_W-1:0]                  word_addr,
    input  pmp_mode_e [NUM_ENTRIES-1:0]        mode_i,
    input  logic [NUM_ENTRIES-1:0][WORD_W-1:0] addr_i,
    output logic [NUM_ENTRIES-1:0]             match_o
);

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_m
        logic in_tor;
        logic in_na4;
        logic in_napot;

        if (i == 0) begin : g_base
            assign in_tor = word_addr < addr_i[i];
        end else begin : g_pair
            assign in_tor = (word_addr >= addr_i[i-1]) && (word_addr < addr_i[i]);
        end

        assign in_na4   = (word_addr == addr_i[i]);
        assign in_napot = ((word_addr ^ addr_i[i]) & napot_care(addr_i[i])) == '0;

        always_comb begin
            case (mode_i[i])
                MODE_TOR:   match_o[i] = in_tor;
                MODE_NA4:   match_o[i] = in_na4;
                MODE_NAPOT: match_o[i] = in_napot;
                default:    match_o[i] = 1'b0;
            endcase
        end

        // R13: an off entry never reports a match
        p_off_no_match_r13: assert property (@(posedge clk) disable iff (rst)
            match_o[i] |-> (mode_i[i] != MODE_OFF));
    end

endmodule

// File: rtl/pmp_prio_select.sv
module pmp_prio_select
    import pmp_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_ENTRIES-1:0]        match_i,
    input  logic [NUM_ENTRIES-1:0][2:0]   xwr_i,
    input  logic [NUM_ENTRIES-1:0]        lock_i,
    input  pmp_acc_e                      acc_i,
    input  logic [1:0]                    priv_i,
    output logic                          allow_o
);

    logic [NUM_ENTRIES-1:0] winner;
    logic [2:0]             sel_xwr;
    logic                   sel_lock;
    logic                   is_mach;

    assign winner  = match_i & (~match_i + 1'b1);
    assign is_mach = (priv_i == PRIV_M);

    always_comb begin
        sel_xwr  = '0;
        sel_lock = 1'b0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (winner[i]) begin
                sel_xwr  = sel_xwr | xwr_i[i];
                sel_lock = sel_lock | lock_i[i];
            end
        end
    end

    always_comb begin
        if (match_i == '0)
            allow_o = is_mach;
        else if (is_mach && !sel_lock)
            allow_o = 1'b1;
        else
            allow_o = right_ok(sel_xwr, acc_i);
    end

    // R7: exactly one decider whenever anything matches, and it is a matcher
    p_single_winner_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(winner) && ((winner == '0) == (match_i == '0)));
    p_winner_in_match_r7: assert property (@(posedge clk) disable iff (rst)
        (winner & ~match_i) == '0);

endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
    import pmp_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 csr_we,
    input  logic [CSR_IDX_W-1:0] csr_idx,
    input  logic [WORD_W-1:0]    csr_wdata,
    output logic [WORD_W-1:0]    csr_rdata,
    input  logic                 chk_valid,
    input  logic [PHYS_W-1:0]    chk_addr,
    input  logic [1:0]           chk_acc,
    input  logic [1:0]           chk_priv,
    output logic                 res_valid,
    output logic                 res_allow
);

    pmp_cfg_t [NUM_ENTRIES-1:0]         cfg;
    logic [NUM_ENTRIES-1:0][WORD_W-1:0] addr;
    logic                               any_lock;
    pmp_mode_e [NUM_ENTRIES-1:0]        mode_v;
    logic [NUM_ENTRIES-1:0][2:0]        xwr_v;
    logic [NUM_ENTRIES-1:0]             lock_v;
    logic [NUM_ENTRIES-1:0]             match_v;
    logic                               allow;
    logic                               unused_bits;
    logic [2*NUM_ENTRIES-1:0]           unused_rsvd;

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_split
        assign mode_v[i] = cfg[i].mode;
        assign xwr_v[i]  = {cfg[i].x, cfg[i].w, cfg[i].r};
        assign lock_v[i] = cfg[i].lock;
        assign unused_rsvd[2*i +: 2] = cfg[i].rsvd;
    end
    assign unused_bits = ^{chk_addr[1:0], unused_rsvd};

    pmp_csr_file #(.NUM_ENTRIES(NUM_ENTRIES)) u_csr (
        .clk        (clk),
        .rst        (rst),
        .csr_we     (csr_we),
        .csr_idx    (csr_idx),
        .csr_wdata  (csr_wdata),
        .csr_rdata  (csr_rdata),
        .cfg_o      (cfg),
        .addr_o     (addr),
        .any_lock_o (any_lock)
    );

    pmp_region_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
        .clk       (clk),
        .rst       (rst),
        .word_addr (chk_addr[PHYS_W-1:2]),
        .mode_i    (mode_v),
        .addr_i    (addr),
        .match_o   (match_v)
    );

    pmp_prio_select #(.NUM_ENTRIES(NUM_ENTRIES)) u_sel (
        .clk     (clk),
        .rst     (rst),
        .match_i (match_v),
        .xwr_i   (xwr_v),
        .lock_i  (lock_v),
        .acc_i   (pmp_acc_e'(chk_acc)),
        .priv_i  (chk_priv),
        .allow_o (allow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_allow <= 1'b0;
        end else begin
            res_valid <= chk_valid;
            res_allow <= chk_valid && allow;
        end
    end

    // R12: one result per request, one cycle later
    p_latency_r12: assert property (@(posedge clk) disable iff (rst)
        chk_valid |=> res_valid);
    p_no_spurious_r12: assert property (@(posedge clk) disable iff (rst)
        !chk_valid |=> !res_valid);
    // R9: machine accesses pass while nothing is locked
    p_mach_free_r9: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && chk_priv == PRIV_M && !any_lock) |=> res_allow);
    // R8: lower privilege with no matching entry is refused
    p_nomatch_deny_r8: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && chk_priv != PRIV_M && match_v == '0) |=> !res_allow);

endmodule

// File: tb/pmp_checker_tb.sv
`timescale 1ns/1ps
module pmp_checker_tb;

    localparam int N = 16;
    localparam logic [1:0] U = 2'd0, S = 2'd1, M = 2'd3;
    localparam logic [1:0] RD = 2'd0, WR = 2'd1, EX = 2'd2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_we = 1'b0;
    logic [5:0]  csr_idx = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        chk_valid = 1'b0;
    logic [33:0] chk_addr = '0;
    logic [1:0]  chk_acc = '0;
    logic [1:0]  chk_priv = '0;
    logic        res_valid;
    logic        res_allow;

    int total = 0;
    int bad   = 0;
    logic  exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    pmp_checker #(.NUM_ENTRIES(N)) u_dut (
        .clk(clk), .rst(rst),
        .csr_we(csr_we), .csr_idx(csr_idx), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .chk_valid(chk_valid), .chk_addr(chk_addr), .chk_acc(chk_acc), .chk_priv(chk_priv),
        .res_valid(res_valid), .res_allow(res_allow)
    );

    // Monitor: pops one expected item per result
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R12 unexpected result: actual=%0b expected=none", res_allow);
            end else begin
                automatic logic  e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (res_allow !== e) begin
                    bad++;
                    $display("FAIL %s: actual=%0b expected=%0b", t, res_allow, e);
                end
            end
        end
    end

    task automatic acc_chk(input logic [33:0] a, input logic [1:0] ty,
                           input logic [1:0] pv, input logic e, input string t);
        @(negedge clk);
        chk_addr = a; chk_acc = ty; chk_priv = pv; chk_valid = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        chk_valid = 1'b0;
    endtask

    task automatic csr_wr(input logic [5:0] i, input logic [31:0] d);
        @(negedge clk);
        csr_idx = i; csr_wdata = d; csr_we = 1'b1;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_chk(input logic [5:0] i, input logic [31:0] e, input string t);
        @(negedge clk);
        csr_idx = i; csr_we = 1'b0;
        #1;
        total++;
        if (csr_rdata !== e) begin
            bad++;
            $display("FAIL %s: idx=%0d actual=%h expected=%h", t, i, csr_rdata, e);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        csr_chk(6'd0,  32'h0, "R1 cfg0");
        csr_chk(6'd3,  32'h0, "R1 cfg3");
        csr_chk(6'd16, 32'h0, "R1 addr0");
        acc_chk(34'h100, RD, U, 1'b0, "R1 user denied");
        acc_chk(34'h100, EX, M, 1'b1, "R1 machine allowed");

        // R3 entry0 TOR [0,0x1000) R|X
        csr_wr(6'd16, 32'h400);
        csr_wr(6'd0,  32'h0000_000D);
        acc_chk(34'h0FFC, RD, U, 1'b1, "R3 below top");
        acc_chk(34'h1000, RD, U, 1'b0, "R3 top exclusive");
        acc_chk(34'h0000, WR, U, 1'b0, "R6 write lacks W");
        acc_chk(34'h0800, EX, U, 1'b1, "R6 exec has X");

        // R2 reserved bits; R3 entry1 TOR [0x1000,0x2000) R|W
        csr_wr(6'd17, 32'h800);
        csr_wr(6'd0,  32'h0060_0B0D);
        csr_chk(6'd0, 32'h0000_0B0D, "R2 reserved bits read zero");
        acc_chk(34'h1000, WR, U, 1'b1, "R3 lower bound inclusive");
        acc_chk(34'h1FFC, EX, U, 1'b0, "R6 exec lacks X");
        acc_chk(34'h1800, RD, S, 1'b1, "R6 supervisor read");

        // R4 entry2 NA4 at 0x3000 R
        csr_wr(6'd18, 32'hC00);
        csr_wr(6'd0,  32'h0011_0B0D);
        acc_chk(34'h3000, RD, U, 1'b1, "R4 exact word");
        acc_chk(34'h3003, RD, U, 1'b1, "R4 same word");
        acc_chk(34'h3004, RD, U, 1'b0, "R4 next word");

        // R5 entry4 NAPOT 0x8000 size 256 X
        csr_wr(6'd20, 32'h201F);
        csr_wr(6'd1,  32'h0000_001C);
        acc_chk(34'h8000, EX, U, 1'b1, "R5 base");
        acc_chk(34'h80FC, EX, U, 1'b1, "R5 last word");
        acc_chk(34'h8100, EX, U, 1'b0, "R5 past end");
        acc_chk(34'h7FFC, EX, U, 1'b0, "R5 before base");

        // R7 entry5 NAPOT 0x8000 size 4K RWX
        csr_wr(6'd21, 32'h21FF);
        csr_wr(6'd1,  32'h0000_1F1C);
        acc_chk(34'h8010, RD, U, 1'b0, "R7 lower entry decides");
        acc_chk(34'h8200, RD, U, 1'b1, "R7 only higher entry");

        // R13 entry3 off with all-ones address
        csr_wr(6'd19, 32'hFFFF_FFFF);
        csr_wr(6'd0,  32'h0711_0B0D);
        csr_chk(6'd0, 32'h0711_0B0D, "R2 cfg0 readback");
        acc_chk(34'hF000, RD, U, 1'b0, "R13 off entry ignored");

        // R8 no match
        acc_chk(34'h2_0000, RD, M, 1'b1, "R8 machine no match");
        acc_chk(34'h2_0000, RD, S, 1'b0, "R8 supervisor no match");
        acc_chk(34'h0000,   WR, M, 1'b1, "R9 machine unlocked match");

        // R9/R10/R11 lock entry1
        csr_wr(6'd0, 32'h0711_8B0D);
        acc_chk(34'h1000, WR, M, 1'b1, "R9 locked grants W");
        acc_chk(34'h1000, EX, M, 1'b0, "R9 locked enforces X");
        csr_wr(6'd0, 32'h0711_0F09);
        csr_chk(6'd0, 32'h0711_8B09, "R10 locked byte kept");
        acc_chk(34'h0800, EX, U, 1'b0, "R10 unlocked byte updated");
        csr_wr(6'd17, 32'h123);
        csr_chk(6'd17, 32'h800, "R10 locked addr kept");
        csr_wr(6'd16, 32'h10);
        csr_chk(6'd16, 32'h400, "R11 prev addr kept");
        acc_chk(34'h0FFC, RD, U, 1'b1, "R11 range unchanged");
        csr_wr(6'd18, 32'hC01);
        csr_chk(6'd18, 32'hC01, "R11 unaffected addr writable");
        acc_chk(34'h3000, RD, U, 1'b0, "R4 moved word old");
        acc_chk(34'h3004, RD, U, 1'b1, "R4 moved word new");

        // R2 unknown index
        csr_wr(6'd8, 32'hFFFF_FFFF);
        csr_chk(6'd8, 32'h0, "R2 unused index");

        // entry 15
        csr_wr(6'd31, 32'h1_0000);
        csr_wr(6'd3,  32'h1100_0000);
        csr_chk(6'd3,  32'h1100_0000, "R2 cfg3 byte3");
        csr_chk(6'd31, 32'h1_0000,    "R2 addr15");
        acc_chk(34'h4_0000, RD, U, 1'b1, "R4 entry15 read");
        acc_chk(34'h4_0000, WR, U, 1'b0, "R6 entry15 write");
        acc_chk(34'h4_0000, 2'd3, U, 1'b0, "R6 type3 never granted");

        repeat (4) @(negedge clk);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R12 missing results: actual=%0d expected=0", exp_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule